// File: doc/BRIEF.md
# Display interface power sequencer

This block orders the switch-on and switch-off of four display interface stages: the pixel clock, the sync timing generator, the display signal and the backlight PWM. Software posts one-hot requests through two set-only write ports. One port asks stages to turn on and the other asks them to turn off. The sequencer holds each request until the stage it depends on reports a stable status. Then it drives that stage's enable. The stage's status follows only after the stage has acknowledged.

Each stage answers its enable with an acknowledge input. A status bit takes the enable's value after a parameterised number of acknowledged cycles. Software is meant to poll the status vector after each request. It moves on once the bit it asked for matches the requested state.

Stage bit positions are fixed: bit 0 is the pixel clock, bit 1 is sync timing, bit 2 is the display signal and bit 3 is the backlight PWM.

Top module: `dps_seq`

## Requirements
- R1: While rst_ni is low, and after reset is released, en_o and status_o are 4'b0000.
- R2: Each 1 bit in en_set_i, sampled on a clock edge, requests that stage on. A 0 bit has no effect. Stages that are already on stay on.
- R3: Each 1 bit in dis_set_i requests that stage off. A 0 bit has no effect. Stages that are already off stay off.
- R4: A stage's en_o rises only once the stage before it in start-up order has status 1. Start-up order is bit 0, bit 1, bit 2, bit 3. Until then the on request stays pending. When it is allowed, en_o changes on the second clock edge after the write.
- R5: An off request is deferred until the stage that must go down before it has status 0. Sync timing (bit 1) waits for the display signal (bit 2). The pixel clock (bit 0) waits for sync timing (bit 1). The backlight (bit 3) waits for the pixel clock (bit 0). The display signal goes off without waiting.
- R6: status_o[k] takes the value of en_o[k] only after ACK_CNT clock edges (default 2) with ack_i[k] high while the two differ. Until then it keeps its old value.
- R7: en_o[k] changes only while en_o[k] equals status_o[k]. A request made during a transition waits until that transition has completed.
- R8: When the same bit is set in en_set_i and dis_set_i on the same edge, the off request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | 4 | One-hot on requests, valid for one cycle |
| dis_set_i | input | 4 | One-hot off requests, valid for one cycle |
| ack_i | input | 4 | Per-stage acknowledge |
| en_o | output | 4 | Per-stage enable |
| status_o | output | 4 | Per-stage stable status |

## Verification
The bench posts an on request for a stage whose prerequisite is off. A design that ignored dependencies would raise that stage's enable at once. The bench also asks for the pixel clock and the backlight to go off while their dependents are still on. Releasing the blocker must then trigger a chained shutdown. The bench holds the acknowledge low and pulses it one cycle at a time, so that a status that moves early or counts wrong shows up. It reverses a request in mid-transition and sets the same bit on both ports at once. This catches an enable that toggles before its status settles, and an on request that wins over an off request.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NUM_STAGES = 4;

  typedef enum int {
    STG_PCLK = 0,
    STG_SYNC = 1,
    STG_DISP = 2,
    STG_BKL  = 3
  } stage_e;

  // stage that must be on before stage k may turn on (-1: none)
  function automatic int up_prereq(input int k);
    case (k)
      STG_SYNC: return STG_PCLK;
      STG_DISP: return STG_SYNC;
      STG_BKL:  return STG_DISP;
      default:  return -1;
    endcase
  endfunction

  // stage that must be off before stage k may turn off (-1: none)
  function automatic int dn_prereq(input int k);
    case (k)
      STG_SYNC: return STG_DISP;
      STG_PCLK: return STG_SYNC;
      STG_BKL:  return STG_PCLK;
      default:  return -1;
    endcase
  endfunction
endpackage

// File: rtl/dps_gate.sv
module dps_gate
  import dps_pkg::*;
#(
  parameter int N = NUM_STAGES
) (
  input  logic [N-1:0] status_i,
  output logic [N-1:0] up_ok_o,
  output logic [N-1:0] dn_ok_o
);
  for (genvar k = 0; k < N; k++) begin : g_gate
    localparam int UP = up_prereq(k);
    localparam int DN = dn_prereq(k);
    if (UP < 0) begin : g_up_free
      assign up_ok_o[k] = 1'b1;
    end else begin : g_up_dep
      assign up_ok_o[k] = status_i[UP];
    end
    if (DN < 0) begin : g_dn_free
      assign dn_ok_o[k] = 1'b1;
    end else begin : g_dn_dep
      assign dn_ok_o[k] = ~status_i[DN];
    end
  end
endmodule

// File: rtl/dps_stage.sv
module dps_stage #(
  parameter int ACK_CNT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic up_ok_i,
  input  logic dn_ok_i,
  output logic en_o,
  output logic status_o
);
  localparam int CW = (ACK_CNT > 1) ? $clog2(ACK_CNT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_CNT - 1);

  logic          target_q;
  logic [CW-1:0] cnt_q;
  logic          settled;

  assign settled = (en_o == status_o);

  // off request wins over on request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    target_q <= 1'b0;
    else if (clr_i) target_q <= 1'b0;
    else if (set_i) target_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0;
    end else if (settled) begin
      if (target_q && !en_o && up_ok_i)      en_o <= 1'b1;
      else if (!target_q && en_o && dn_ok_i) en_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      status_o <= 1'b0;
    end else if (settled) begin
      cnt_q <= '0;
    end else if (ack_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        status_o <= en_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dps_seq.sv
module dps_seq
  import dps_pkg::*;
#(
  parameter int ACK_CNT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] en_set_i,
  input  logic [NUM_STAGES-1:0] dis_set_i,
  input  logic [NUM_STAGES-1:0] ack_i,
  output logic [NUM_STAGES-1:0] en_o,
  output logic [NUM_STAGES-1:0] status_o
);
  logic [NUM_STAGES-1:0] up_ok;
  logic [NUM_STAGES-1:0] dn_ok;

  dps_gate #(.N(NUM_STAGES)) u_gate (
    .status_i (status_o),
    .up_ok_o  (up_ok),
    .dn_ok_o  (dn_ok)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    dps_stage #(.ACK_CNT(ACK_CNT)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (en_set_i[k]),
      .clr_i    (dis_set_i[k]),
      .ack_i    (ack_i[k]),
      .up_ok_i  (up_ok[k]),
      .dn_ok_i  (dn_ok[k]),
      .en_o     (en_o[k]),
      .status_o (status_o[k])
    );
  end
endmodule

// File: rtl/dps_seq_chk.sv
module dps_seq_chk
  import dps_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_STAGES-1:0] ack_i,
  input logic [NUM_STAGES-1:0] en_o,
  input logic [NUM_STAGES-1:0] status_o
);
  for (genvar k = 1; k < NUM_STAGES; k++) begin : g_up
    p_order_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_o[k]) |-> $past(status_o[k-1]));
  end

  p_order_dn_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o[STG_SYNC]) |-> !$past(status_o[STG_DISP]));
  p_order_dn_pclk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o[STG_PCLK]) |-> !$past(status_o[STG_SYNC]));
  p_order_dn_bkl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_o[STG_BKL]) |-> !$past(status_o[STG_PCLK]));

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stg
    p_status_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(status_o[k]) |-> ($past(ack_i[k]) && ($past(en_o[k]) == status_o[k])));
    p_en_settled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(en_o[k]) |-> $past(en_o[k] == status_o[k]));
  end
endmodule

bind dps_seq dps_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .en_o     (en_o),
  .status_o (status_o)
);

// File: tb/tb_dps_seq.sv
module tb_dps_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] en_set_i = '0;
  logic [3:0] dis_set_i = '0;
  logic [3:0] ack_i = '0;
  logic [3:0] en_o;
  logic [3:0] status_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dps_seq #(.ACK_CNT(2)) dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_set_i (en_set_i),
    .dis_set_i(dis_set_i),
    .ack_i    (ack_i),
    .en_o     (en_o),
    .status_o (status_o)
  );

  // {en_set, dis_set, exp_en, exp_status}, ack held high, 16 cycles settle
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    16'h1_0_1_1,  // clock on
    16'h4_0_1_1,  // display pending on sync
    16'h2_0_7_7,  // sync on releases display
    16'h0_0_7_7,  // zero write
    16'h8_0_F_F,  // backlight on
    16'h0_1_F_F,  // clock off deferred
    16'h0_4_B_B,  // display off
    16'h0_8_B_B,  // backlight off deferred
    16'h0_2_0_0,  // sync off chains clock then backlight
    16'hF_0_F_F,  // all on
    16'h0_F_0_0   // all off
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic post(input logic [3:0] en, input logic [3:0] dis);
    @(negedge clk_i);
    en_set_i  = en;
    dis_set_i = dis;
    @(negedge clk_i);
    en_set_i  = '0;
    dis_set_i = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_ack(input logic [3:0] m);
    @(negedge clk_i);
    ack_i = m;
    @(negedge clk_i);
    ack_i = '0;
  endtask

  initial begin
    #5;
    check("R1 en in reset", en_o, 4'b0000);
    check("R1 status in reset", status_o, 4'b0000);
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(2);
    check("R1 en after reset", en_o, 4'b0000);
    check("R1 status after reset", status_o, 4'b0000);

    ack_i = 4'hF;
    for (int i = 0; i < NV; i++) begin
      post(VEC[i][15:12], VEC[i][11:8]);
      wait_cyc(16);
      check($sformatf("R2 R3 R4 R5 vec%0d en", i), en_o, VEC[i][7:4]);
      check($sformatf("R2 R3 R4 R5 vec%0d status", i), status_o, VEC[i][3:0]);
    end

    // start-up timing: ends just after the write edge
    post(4'hF, 4'h0);
    wait_cyc(3);
    check("R4 step1 en", en_o, 4'b0001);
    check("R4 step1 status", status_o, 4'b0001);
    wait_cyc(3);
    check("R4 step2 en", en_o, 4'b0011);
    check("R4 step2 status", status_o, 4'b0011);

    // asynchronous reset mid-run
    #3 rst_ni = 1'b0;
    #1;
    check("R1 en mid reset", en_o, 4'b0000);
    check("R1 status mid reset", status_o, 4'b0000);
    wait_cyc(2);
    rst_ni = 1'b1;

    // acknowledge gating
    ack_i = 4'h0;
    post(4'h1, 4'h0);
    wait_cyc(10);
    check("R6 en without ack", en_o, 4'b0001);
    check("R6 status holds without ack", status_o, 4'b0000);
    pulse_ack(4'h1);
    check("R6 status after one ack", status_o, 4'b0000);
    pulse_ack(4'h1);
    check("R6 status after two acks", status_o, 4'b0001);

    // request reversal during transition
    post(4'h0, 4'h1);
    wait_cyc(3);
    check("R7 en off pending ack", en_o, 4'b0000);
    check("R7 status old", status_o, 4'b0001);
    post(4'h1, 4'h0);
    wait_cyc(5);
    check("R7 en held while unsettled", en_o, 4'b0000);
    ack_i = 4'hF;
    wait_cyc(10);
    check("R7 en after settle", en_o, 4'b0001);
    check("R7 status after settle", status_o, 4'b0001);

    // simultaneous on and off
    post(4'h2, 4'h0);
    wait_cyc(8);
    check("R8 sync on", status_o, 4'b0011);
    post(4'h2, 4'h2);
    wait_cyc(8);
    check("R8 off wins en", en_o, 4'b0001);
    check("R8 off wins status", status_o, 4'b0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule